// File: doc/BRIEF.md
# Rotated Binary Patch Descriptor Generator

This block turns one keypoint into a 256-bit binary signature. A 31x31 window of brightness values around the keypoint is first written into an internal register file through a plain write port. A keypoint record, holding a tag and a 4-bit orientation code, is then taken from an upstream queue over a valid/ready handshake. The block turns a fixed set of 256 point pairs by the keypoint's orientation, reads the two pixels of each turned pair, and sets one signature bit per pair by comparing the two brightness values. Eight pairs are handled in each cycle, so a signature takes 32 working cycles. The result and its tag are then offered downstream on a second valid/ready handshake.

The controller has three states. In ST_IDLE the block offers `kp_ready`. The transition "accept" (`kp_valid` high in ST_IDLE) latches the tag and the sine and cosine for the orientation and moves to ST_RUN. In ST_RUN the step counter walks from 0 to 31 and fills eight bits per step. The transition "last step" (step 31) moves to ST_DONE. In ST_DONE the signature is offered. The transition "drain" (`desc_ready` high) returns to ST_IDLE. A new keypoint is only taken after the previous signature has been accepted.

Top module: `rotated_desc_gen`

## Requirements
- R1: Out of reset, `desc_valid` is 0 and `kp_ready` is 1.
- R2: A keypoint is taken on a clock edge where `kp_valid` and `kp_ready` are both 1. `kp_ready` then stays 0 until the edge where the signature is accepted (`desc_valid` and `desc_ready` both 1), and it is 1 again one cycle after that edge.
- R3: `desc_valid` rises exactly 32 clock cycles after the edge that took the keypoint.
- R4: Bit i of `desc_bits` is 1 when pixel A of pair i is strictly less than pixel B of pair i, and 0 otherwise. Equal pixels therefore give 0.
- R5: Pair i (0..255) uses the unrotated offsets ax=((5i+1) mod 27)-13, ay=((11i+4) mod 27)-13, bx=((13i+7) mod 27)-13 and by=((17i+2) mod 27)-13.
- R6: Orientation code k (0..15) stands for k·22.5°. Its cosine is the Q1.14 value from the list 16384, 15137, 11585, 6270, 0, -6270, -11585, -15137, -16384, -15137, -11585, -6270, 0, 6270, 11585, 15137, indexed by k. Its sine is the list entry at index (k+12) mod 16. A point (x,y) maps to x'=(x·c − y·s + 8192)>>14 and y'=(x·s + y·c + 8192)>>14, where >> is an arithmetic shift.
- R7: After the rotation, x' and y' are each clamped to the range −15..+15.
- R8: While `desc_valid` is 1 and `desc_ready` is 0, `desc_valid`, `desc_bits` and `desc_tag` hold their values. `desc_tag` equals the `kp_tag` value that was taken with the keypoint.
- R9: A write with `wr_en` high stores `wr_data` at address `wr_addr`. The pixel at offset (dx,dy) from the keypoint lives at address (dy+15)·31 + (dx+15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Patch pixel write strobe |
| wr_addr | input | 10 | Patch pixel address |
| wr_data | input | PIX_W (8) | Patch pixel brightness |
| kp_valid | input | 1 | Keypoint record offered |
| kp_ready | output | 1 | Block can take a keypoint |
| kp_tag | input | TAG_W (16) | Keypoint tag, returned with the signature |
| kp_angle | input | 4 | Orientation code, in steps of 22.5° |
| desc_valid | output | 1 | Signature offered |
| desc_ready | input | 1 | Downstream accepts the signature |
| desc_bits | output | 256 | Signature, pair i in bit i |
| desc_tag | output | TAG_W (16) | Tag of the keypoint for this signature |

## Verification
The signature is due 32 cycles after the edge that takes the keypoint. `kp_ready` falls one cycle after that edge. After the accepting edge of the output, `kp_ready` returns and `desc_valid` clears one cycle later. The bench drives and samples on falling edges. It counts rising edges from the taking edge until `desc_valid` is seen, expects a count of exactly 32, and only then compares the full 256-bit value against a signature computed from the pair, rotation and clamp formulas over its own copy of the patch. During back-pressure it samples every cycle and checks that the output holds, and that a keypoint offered in that time is not taken.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

    localparam int PATCH_HALF = 15;
    localparam int PATCH_SIDE = 2 * PATCH_HALF + 1;
    localparam int PATCH_NPIX = PATCH_SIDE * PATCH_SIDE;
    localparam int PATCH_AW   = $clog2(PATCH_NPIX);
    localparam int NPAIRS     = 256;
    localparam int CRD_W      = 6;
    localparam int TRIG_W     = 16;
    localparam int TRIG_FRAC  = 14;
    localparam int PAT_MOD    = 27;
    localparam int PAT_BIAS   = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rdg_state_t;

    // one coordinate of the fixed sampling pattern
    function automatic logic signed [CRD_W-1:0] pat_coord(input int idx, input int mul, input int off);
        int v;
        v = ((idx * mul + off) % PAT_MOD) - PAT_BIAS;
        return CRD_W'(v);
    endfunction

    // cosine over the first quarter turn, Q1.14
    function automatic int quarter_cos(input int q);
        int r;
        unique case (q)
            0:       r = 16384;
            1:       r = 15137;
            2:       r = 11585;
            3:       r = 6270;
            default: r = 0;
        endcase
        return r;
    endfunction

    // cosine of code*22.5 degrees, built by symmetry from one quarter
    function automatic logic signed [TRIG_W-1:0] trig_cos(input logic [3:0] code);
        int a;
        int q;
        logic neg;
        a = int'(code);
        if (a <= 4) begin
            q = quarter_cos(a);      neg = 1'b0;
        end else if (a <= 8) begin
            q = quarter_cos(8 - a);  neg = 1'b1;
        end else if (a <= 12) begin
            q = quarter_cos(a - 8);  neg = 1'b1;
        end else begin
            q = quarter_cos(16 - a); neg = 1'b0;
        end
        return neg ? TRIG_W'(-q) : TRIG_W'(q);
    endfunction

    function automatic logic signed [TRIG_W-1:0] trig_sin(input logic [3:0] code);
        return trig_cos(code + 4'd12);
    endfunction

endpackage

// File: rtl/rdg_patch_mem.sv
module rdg_patch_mem #(
    parameter int PIX_W  = 8,
    parameter int NPIX   = 961,
    parameter int AW     = 10,
    parameter int NRD    = 16
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [PIX_W-1:0]      wr_data,
    input  logic [NRD*AW-1:0]     rd_addr,
    output logic [NRD*PIX_W-1:0]  rd_data
);

    logic [PIX_W-1:0] cells [NPIX];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < NPIX)) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // independent combinational read ports
    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign rd_data[p*PIX_W +: PIX_W] = cells[rd_addr[p*AW +: AW]];
    end

endmodule

// File: rtl/rdg_rotate.sv
module rdg_rotate
    import rdg_pkg::*;
(
    input  logic signed [CRD_W-1:0]  pt_x,
    input  logic signed [CRD_W-1:0]  pt_y,
    input  logic signed [TRIG_W-1:0] cos_v,
    input  logic signed [TRIG_W-1:0] sin_v,
    output logic [PATCH_AW-1:0]      addr
);

    localparam int ROUND_ADD = 1 << (TRIG_FRAC - 1);

    int xi, yi, ci, si, rx, ry;

    always_comb begin
        xi = int'(pt_x);
        yi = int'(pt_y);
        ci = int'(cos_v);
        si = int'(sin_v);
        rx = (xi * ci - yi * si + ROUND_ADD) >>> TRIG_FRAC;
        ry = (xi * si + yi * ci + ROUND_ADD) >>> TRIG_FRAC;
        if (rx > PATCH_HALF)       rx = PATCH_HALF;
        else if (rx < -PATCH_HALF) rx = -PATCH_HALF;
        if (ry > PATCH_HALF)       ry = PATCH_HALF;
        else if (ry < -PATCH_HALF) ry = -PATCH_HALF;
        addr = PATCH_AW'((ry + PATCH_HALF) * PATCH_SIDE + (rx + PATCH_HALF));
    end

endmodule

// File: rtl/rotated_desc_gen.sv
module rotated_desc_gen
    import rdg_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TAG_W = 16,
    parameter int LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PATCH_AW-1:0]  wr_addr,
    input  logic [PIX_W-1:0]     wr_data,
    input  logic                 kp_valid,
    output logic                 kp_ready,
    input  logic [TAG_W-1:0]     kp_tag,
    input  logic [3:0]           kp_angle,
    output logic                 desc_valid,
    input  logic                 desc_ready,
    output logic [NPAIRS-1:0]    desc_bits,
    output logic [TAG_W-1:0]     desc_tag
);

    localparam int STEPS = NPAIRS / LANES;
    localparam int SW    = $clog2(STEPS);
    localparam int NRD   = 2 * LANES;

    rdg_state_t                state, state_nx;
    logic [SW-1:0]             step;
    logic signed [TRIG_W-1:0]  cos_r, sin_r;
    logic [TAG_W-1:0]          tag_r;
    logic [NPAIRS-1:0]         sig_r;
    logic [LANES-1:0]          lane_bit;
    logic [NRD*PATCH_AW-1:0]   rd_addr;
    logic [NRD*PIX_W-1:0]      rd_data;

    rdg_patch_mem #(
        .PIX_W (PIX_W),
        .NPIX  (PATCH_NPIX),
        .AW    (PATCH_AW),
        .NRD   (NRD)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // one comparison lane per pair evaluated in a step
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        int                      pidx;
        logic signed [CRD_W-1:0] ax, ay, bx, by;
        logic [PIX_W-1:0]        pix_a, pix_b;

        always_comb begin
            pidx = int'(step) * LANES + j;
            ax   = pat_coord(pidx, 5, 1);
            ay   = pat_coord(pidx, 11, 4);
            bx   = pat_coord(pidx, 13, 7);
            by   = pat_coord(pidx, 17, 2);
        end

        rdg_rotate u_rot_a (
            .pt_x  (ax),
            .pt_y  (ay),
            .cos_v (cos_r),
            .sin_v (sin_r),
            .addr  (rd_addr[(2*j)*PATCH_AW +: PATCH_AW])
        );

        rdg_rotate u_rot_b (
            .pt_x  (bx),
            .pt_y  (by),
            .cos_v (cos_r),
            .sin_v (sin_r),
            .addr  (rd_addr[(2*j+1)*PATCH_AW +: PATCH_AW])
        );

        assign pix_a       = rd_data[(2*j)*PIX_W +: PIX_W];
        assign pix_b       = rd_data[(2*j+1)*PIX_W +: PIX_W];
        assign lane_bit[j] = (pix_a < pix_b);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, last step, drain
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (kp_valid)                  state_nx = ST_RUN;
            ST_RUN:  if (step == SW'(STEPS - 1))    state_nx = ST_DONE;
            ST_DONE: if (desc_ready)                state_nx = ST_IDLE;
            default:                                state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step  <= '0;
            cos_r <= '0;
            sin_r <= '0;
            tag_r <= '0;
            sig_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (kp_valid) begin
                        step  <= '0;
                        tag_r <= kp_tag;
                        cos_r <= trig_cos(kp_angle);
                        sin_r <= trig_sin(kp_angle);
                    end
                end
                ST_RUN: begin
                    sig_r[int'(step) * LANES +: LANES] <= lane_bit;
                    step <= step + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        kp_ready   = (state == ST_IDLE);
        desc_valid = (state == ST_DONE);
        desc_bits  = sig_r;
        desc_tag   = tag_r;
    end

endmodule

// File: rtl/rdg_checker.sv
module rdg_checker #(
    parameter int NBITS = 256,
    parameter int TAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kp_valid,
    input logic             kp_ready,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [NBITS-1:0] desc_bits,
    input logic [TAG_W-1:0] desc_tag
);

    localparam int LAT = 32;

    logic [6:0] since_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    since_take <= '0;
        else if (kp_valid && kp_ready) since_take <= 7'd1;
        else if (since_take != 7'd0 && !desc_valid) since_take <= since_take + 7'd1;
    end

    // R2: after a keypoint is taken, no further keypoint is offered ready
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (kp_valid && kp_ready) |=> !kp_ready);

    // R2: never ready for input while a signature is pending
    a_r2_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !kp_ready);

    // R3: the signature appears 32 cycles after the taking edge
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_valid) |-> (since_take == 7'(LAT + 1)));

    // R8: output holds under back-pressure
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_bits) && $stable(desc_tag)));

endmodule

bind rotated_desc_gen rdg_checker #(
    .NBITS (rdg_pkg::NPAIRS),
    .TAG_W (TAG_W)
) u_chk (.*);

// File: tb/rotated_desc_gen_tb.sv
module rotated_desc_gen_tb;

    localparam int NPIX = 961;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [9:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         kp_valid = 1'b0;
    logic         kp_ready;
    logic [15:0]  kp_tag = '0;
    logic [3:0]   kp_angle = '0;
    logic         desc_valid;
    logic         desc_ready = 1'b0;
    logic [255:0] desc_bits;
    logic [15:0]  desc_tag;

    int total = 0;
    int bad   = 0;
    int pix [NPIX];

    // Q1.14 cosine per orientation code, from R6
    int cos_tab [16] = '{16384, 15137, 11585, 6270, 0, -6270, -11585, -15137,
                         -16384, -15137, -11585, -6270, 0, 6270, 11585, 15137};

    always #2 clk = ~clk;

    rotated_desc_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .kp_valid(kp_valid), .kp_ready(kp_ready), .kp_tag(kp_tag), .kp_angle(kp_angle),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_bits(desc_bits), .desc_tag(desc_tag)
    );

    task automatic check(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int rot_clamp(input int v);
        int r;
        r = (v + 8192) >>> 14;
        if (r > 15) r = 15;
        if (r < -15) r = -15;
        return r;
    endfunction

    function automatic int pix_at(input int x, input int y, input int c, input int s);
        int rx, ry;
        rx = rot_clamp(x * c - y * s);
        ry = rot_clamp(x * s + y * c);
        return pix[(ry + 15) * 31 + (rx + 15)];
    endfunction

    function automatic logic [255:0] expect_sig(input int ang);
        logic [255:0] e;
        int c, s;
        c = cos_tab[ang];
        s = cos_tab[(ang + 12) % 16];
        for (int i = 0; i < 256; i++) begin
            int ax, ay, bx, by;
            ax = ((5 * i + 1) % 27) - 13;
            ay = ((11 * i + 4) % 27) - 13;
            bx = ((13 * i + 7) % 27) - 13;
            by = ((17 * i + 2) % 27) - 13;
            e[i] = (pix_at(ax, ay, c, s) < pix_at(bx, by, c, s));
        end
        return e;
    endfunction

    // mode 0 flat, 1 column ramp, 2 row ramp, 3 scrambled
    task automatic load_patch(input int mode, input int seed);
        for (int a = 0; a < NPIX; a++) begin
            int v;
            unique case (mode)
                0: v = 100;
                1: v = (a % 31) * 8;
                2: v = (a / 31) * 8;
                default: v = ((a * 73 + seed * 29) ^ (a >> 3)) & 255;
            endcase
            pix[a] = v;
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = 10'(a);
            wr_data = 8'(v);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // take one keypoint, check latency, value, tag, hold and drain
    task automatic run_kp(input string req, input logic [15:0] tag, input int ang, input int hold);
        int lat;
        logic [255:0] exp_sig, first;
        exp_sig = expect_sig(ang);
        @(negedge clk);
        check("R2", "ready before take", 256'(kp_ready), 256'(1));
        kp_valid = 1'b1;
        kp_tag   = tag;
        kp_angle = 4'(ang);
        @(posedge clk);
        @(negedge clk);
        kp_valid = 1'b0;
        check("R2", "ready after take", 256'(kp_ready), 256'(0));
        lat = 0;
        while (!desc_valid && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check("R3", "latency", 256'(lat), 256'(32));
        check(req, "signature", desc_bits, exp_sig);
        check("R8", "tag", 256'(desc_tag), 256'(tag));
        first = desc_bits;
        if (hold > 0) begin
            kp_valid = 1'b1;
            kp_tag   = ~tag;
            for (int h = 0; h < hold; h++) begin
                @(posedge clk);
                @(negedge clk);
                check("R8", "valid held", 256'(desc_valid), 256'(1));
                check("R8", "bits held", desc_bits, first);
                check("R2", "no take while pending", 256'(kp_ready), 256'(0));
            end
            kp_valid = 1'b0;
        end
        desc_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        desc_ready = 1'b0;
        check("R2", "valid cleared after drain", 256'(desc_valid), 256'(0));
        check("R2", "ready back after drain", 256'(kp_ready), 256'(1));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "valid at reset", 256'(desc_valid), 256'(0));
        check("R1", "ready at reset", 256'(kp_ready), 256'(1));
    endtask

    task automatic t_flat;
        load_patch(0, 0);
        run_kp("R4", 16'h0101, 5, 0);
        check("R4", "equal pixels give zero", desc_bits, '0);
    endtask

    task automatic t_address;
        load_patch(1, 0);
        run_kp("R9", 16'h0201, 0, 0);
        load_patch(2, 0);
        run_kp("R9", 16'h0202, 0, 0);
    endtask

    task automatic t_pattern;
        load_patch(3, 7);
        run_kp("R5", 16'h0301, 0, 0);
    endtask

    task automatic t_rotation;
        load_patch(3, 11);
        run_kp("R6", 16'h0401, 4, 0);
        run_kp("R6", 16'h0402, 8, 0);
        run_kp("R6", 16'h0403, 3, 0);
        run_kp("R6", 16'h0404, 11, 0);
    endtask

    task automatic t_clamp;
        load_patch(3, 23);
        run_kp("R7", 16'h0501, 2, 0);
        run_kp("R7", 16'h0502, 14, 0);
    endtask

    task automatic t_backpressure;
        load_patch(3, 5);
        run_kp("R8", 16'h0601, 1, 12);
        run_kp("R2", 16'h0602, 9, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flat();
        t_address();
        t_pattern();
        t_rotation();
        t_clamp();
        t_backpressure();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule